// File: doc/BRIEF.md
# Code-Store Protection Gate

This block decides, cycle by cycle, which accesses to the on-chip code store are allowed. It reads three non-volatile protection bits and derives a protection tier from them. Each tier keeps every restriction of the tier below it and adds one more. Five request flags come in: internal instruction fetch, a table read issued by code running from external memory, read-back verify, flash write, and external instruction fetch. Each flag is answered at once with a grant or a deny.

The block also owns the code-source select. This signal chooses whether instructions come from internal or external memory. When the first protection bit is clear, the select follows the external-access pin directly. When that bit is set, the select is the pin value captured while reset was held, and later pin activity does not change it. That captured value has no defined state until the first reset.

Top module: `code_lock_guard`

## Requirements
- R1: `lock_bits` uses 1 for a programmed bit, and bit 0 is the first bit. The tier is 0 when no bit is programmed. Otherwise the tier is one plus the index of the highest programmed bit, so the highest set bit alone decides the tier.
- R2: At tier 0, every request is granted subject only to R8.
- R3: At tier 1 and above, the external table read (`req[1]`) and the flash write (`req[3]`) are denied.
- R4: At tier 2 and above, read-back verify (`req[2]`) is also denied.
- R5: At tier 3, external instruction fetch (`req[4]`) is also denied.
- R6: With `lock_bits[0]` at 0, `code_sel` equals `ea_pin` in the same cycle.
- R7: With `lock_bits[0]` at 1, `code_sel` equals the `ea_pin` value present at the last rising clock edge on which `rst` was high. Pin changes after reset have no effect on it.
- R8: Internal fetch (`req[0]`) is granted only while `code_sel` is 1. External fetch (`req[4]`) is granted only while `code_sel` is 0.
- R9: While `rst` is high, no grant is given. At all times `deny` equals `req` with the granted bits cleared, and no bit is granted without its request.
- R10: When bit 0 is clear but a higher bit is set, the tier still follows R1 and `code_sel` stays live as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also the capture window for the pin |
| lock_bits | input | 3 | Protection bits, 1 = programmed |
| ea_pin | input | 1 | External-access pin level, 1 = internal code |
| req | input | 5 | Requests: 0 int fetch, 1 ext table read, 2 verify, 3 flash write, 4 ext fetch |
| grant | output | 5 | Per-request grant, same bit order |
| deny | output | 5 | Per-request deny, same bit order |
| code_sel | output | 1 | Effective code-source select, 1 = internal |

## Verification
The bench runs all eight protection-bit patterns. For each pattern it captures both pin levels during reset and then toggles the pin against every request mix. This shows whether a design follows the pin live, holds the captured value, or loses that value when the pin moves after reset. The patterns where bit 0 is clear but a higher bit is set check the R1 rule. A decoder that instead counted programmed bits, or that demanded contiguous bits, would grant verify or external fetch where R1 denies them. Asserting reset with requests active checks R9: a design that gated only some grants on reset would show a grant there.

// File: rtl/lockguard_pkg.sv
`timescale 1ns/1ps
package lockguard_pkg;

  typedef enum logic [1:0] {
    TIER_OPEN    = 2'd0,
    TIER_NOREAD  = 2'd1,
    TIER_NOCHECK = 2'd2,
    TIER_NOEXT   = 2'd3
  } tier_e;

  localparam int LOCK_W = 3;
  localparam int REQ_W  = 5;

  localparam int RQ_INT_FETCH = 0;
  localparam int RQ_TBL_READ  = 1;
  localparam int RQ_VERIFY    = 2;
  localparam int RQ_FLASH_WR  = 3;
  localparam int RQ_EXT_FETCH = 4;

  // Tier from the highest programmed bit (bit i set -> tier i+1).
  function automatic tier_e tier_of(input logic [LOCK_W-1:0] bits);
    tier_e t;
    t = TIER_OPEN;
    for (int i = 0; i < LOCK_W; i++) begin
      if (bits[i]) t = tier_e'(2'(i + 1));
    end
    return t;
  endfunction

  // Highest tier at which a request class may still be granted.
  function automatic tier_e ceiling_of(input int idx);
    case (idx)
      RQ_INT_FETCH: return TIER_NOEXT;
      RQ_TBL_READ:  return TIER_OPEN;
      RQ_VERIFY:    return TIER_NOREAD;
      RQ_FLASH_WR:  return TIER_OPEN;
      RQ_EXT_FETCH: return TIER_NOCHECK;
      default:      return TIER_OPEN;
    endcase
  endfunction

  // Code-source condition a request class needs: 0 none, 1 internal, 2 external.
  function automatic logic [1:0] source_need(input int idx);
    case (idx)
      RQ_INT_FETCH: return 2'd1;
      RQ_EXT_FETCH: return 2'd2;
      default:      return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/clg_tier_decode.sv
`timescale 1ns/1ps
module clg_tier_decode
  import lockguard_pkg::*;
(
  input  logic [LOCK_W-1:0] lock_bits,
  output tier_e             tier,
  output logic              first_set
);
  always_comb begin
    tier      = tier_of(lock_bits);
    first_set = lock_bits[0];
  end
endmodule

// File: rtl/clg_sel_capture.sv
`timescale 1ns/1ps
module clg_sel_capture (
  input  logic clk,
  input  logic rst,
  input  logic use_captured,
  input  logic ea_pin,
  output logic code_sel
);
  logic held_q;

  // Captured only while reset is asserted; no power-up value on purpose.
  always_ff @(posedge clk) begin
    if (rst) held_q <= ea_pin;
  end

  always_comb code_sel = use_captured ? held_q : ea_pin;
endmodule

// File: rtl/clg_req_gate.sv
`timescale 1ns/1ps
module clg_req_gate
  import lockguard_pkg::*;
#(
  parameter int N = REQ_W
) (
  input  logic         rst,
  input  tier_e        tier,
  input  logic         code_sel,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [N-1:0] deny
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam tier_e      CEIL = ceiling_of(g);
    localparam logic [1:0] NEED = source_need(g);
    logic tier_ok, src_ok;
    always_comb begin
      tier_ok = (tier <= CEIL);
      case (NEED)
        2'd1:    src_ok = code_sel;
        2'd2:    src_ok = !code_sel;
        default: src_ok = 1'b1;
      endcase
      grant[g] = !rst && req[g] && tier_ok && src_ok;
      deny[g]  = req[g] && !grant[g];
    end
  end
endmodule

// File: rtl/code_lock_guard.sv
`timescale 1ns/1ps
module code_lock_guard
  import lockguard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LOCK_W-1:0] lock_bits,
  input  logic              ea_pin,
  input  logic [REQ_W-1:0]  req,
  output logic [REQ_W-1:0]  grant,
  output logic [REQ_W-1:0]  deny,
  output logic              code_sel
);
  tier_e tier_w;
  logic  first_set_w;

  clg_tier_decode u_dec (
    .lock_bits (lock_bits),
    .tier      (tier_w),
    .first_set (first_set_w)
  );

  clg_sel_capture u_sel (
    .clk          (clk),
    .rst          (rst),
    .use_captured (first_set_w),
    .ea_pin       (ea_pin),
    .code_sel     (code_sel)
  );

  clg_req_gate #(.N(REQ_W)) u_gate (
    .rst      (rst),
    .tier     (tier_w),
    .code_sel (code_sel),
    .req      (req),
    .grant    (grant),
    .deny     (deny)
  );
endmodule

// File: rtl/code_lock_guard_chk.sv
`timescale 1ns/1ps
module code_lock_guard_chk
  import lockguard_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [LOCK_W-1:0] lock_bits,
  input logic              ea_pin,
  input logic [REQ_W-1:0]  req,
  input logic [REQ_W-1:0]  grant,
  input logic [REQ_W-1:0]  deny,
  input logic              code_sel,
  input tier_e             tier
);
  // R3
  tbl_read_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (tier >= TIER_NOREAD) |-> (!grant[RQ_TBL_READ] && !grant[RQ_FLASH_WR]));
  // R4
  verify_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (tier >= TIER_NOCHECK) |-> !grant[RQ_VERIFY]);
  // R5
  ext_fetch_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (tier == TIER_NOEXT) |-> !grant[RQ_EXT_FETCH]);
  // R6
  sel_live_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_bits[0] |-> (code_sel == ea_pin));
  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_bits[0] && $past(lock_bits[0]) && !$past(rst)) |-> $stable(code_sel));
  // R8
  int_fetch_src_chk: assert property (@(posedge clk) disable iff (rst)
    grant[RQ_INT_FETCH] |-> code_sel);
  // R8
  ext_fetch_src_chk: assert property (@(posedge clk) disable iff (rst)
    grant[RQ_EXT_FETCH] |-> !code_sel);
  // R9
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((grant & ~req) == '0) && ((grant & deny) == '0));
endmodule

bind code_lock_guard code_lock_guard_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .lock_bits (lock_bits),
  .ea_pin    (ea_pin),
  .req       (req),
  .grant     (grant),
  .deny      (deny),
  .code_sel  (code_sel),
  .tier      (tier_w)
);

// File: tb/code_lock_guard_tb_top.sv
`timescale 1ns/1ps
module code_lock_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] lock_bits = 3'b000;
  logic       ea_pin = 1'b1;
  logic [4:0] req = 5'b0;
  logic [4:0] grant, deny;
  logic       code_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic m_held;

  always #5 clk = ~clk;

  code_lock_guard dut_i (
    .clk(clk), .rst(rst), .lock_bits(lock_bits), .ea_pin(ea_pin),
    .req(req), .grant(grant), .deny(deny), .code_sel(code_sel)
  );

  // Reference: pin value held from the last edge seen in reset (R7)
  always @(posedge clk) if (rst) m_held <= ea_pin;

  // R1: tier set by the highest programmed bit
  function automatic int model_tier(input logic [2:0] b);
    if (b[2]) return 3;
    if (b[1]) return 2;
    if (b[0]) return 1;
    return 0;
  endfunction

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (lock=%b pin=%b req=%b rst=%b)",
               tag, act, exp, lock_bits, ea_pin, req, rst);
    end
  endtask

  task automatic step(input logic [2:0] lk, input logic p, input logic [4:0] r,
                      input logic rs);
    int  t;
    logic sel_exp;
    logic [4:0] g_exp;
    string tag;
    @(negedge clk);
    lock_bits = lk; ea_pin = p; req = r; rst = rs;
    #1;
    t = model_tier(lk);
    sel_exp = lk[0] ? m_held : p;
    if (!(lk[0] && $isunknown(m_held)))
      check1(lk[0] ? "R7" : (t > 0 ? "R10" : "R6"), code_sel, sel_exp);
    g_exp[0] = r[0] && sel_exp;
    g_exp[1] = r[1] && (t == 0);
    g_exp[2] = r[2] && (t <= 1);
    g_exp[3] = r[3] && (t == 0);
    g_exp[4] = r[4] && !sel_exp && (t <= 2);
    if (rs) g_exp = 5'b0;
    for (int i = 0; i < 5; i++) begin
      if (rs) tag = "R9";
      else if (!lk[0] && t > 0) tag = "R10";
      else if (i == 0) tag = "R8";
      else if (i == 4) tag = (t == 3) ? "R5" : "R8";
      else if (i == 2) tag = (t >= 2) ? "R4" : "R1 R2";
      else tag = (t >= 1) ? "R3" : "R1 R2";
      check1(tag, grant[i], g_exp[i]);
    end
    checks++;
    if (deny !== (r & ~g_exp)) begin
      fails++;
      $display("FAIL R9: deny got %b expected %b", deny, r & ~g_exp);
    end
  endtask

  initial begin
    // reset state: nothing granted while reset is held (R9)
    step(3'b000, 1'b1, 5'b11111, 1'b1);
    step(3'b000, 1'b1, 5'b11111, 1'b1);
    for (int lk = 0; lk < 8; lk++) begin
      for (int prst = 0; prst < 2; prst++) begin
        step(3'(lk), 1'(prst), 5'b11111, 1'b1);
        step(3'(lk), 1'(prst), 5'b10101, 1'b1);
        for (int p = 0; p < 2; p++) begin
          for (int r = 0; r < 32; r++) begin
            // pin flips after reset: captured select must not follow (R7)
            step(3'(lk), 1'(p ^ (r & 1)), 5'(r), 1'b0);
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule